// File: doc/BRIEF.md
# Serial Control Bus Register Slave

This block is the target side of a three-wire control bus. A master drives a bus clock, an active-low frame enable and, for most of a frame, a shared data line. Each frame carries a 3-bit device select, a direction bit, a 5-bit register index and 16 data bits, all sent most significant bit first. The slave responds only to device select `101`. A write frame loads the addressed 16-bit register in an attached register file. A read frame hands the data line back to the slave, which then shifts out the addressed register.

All three bus inputs are synchronised into the fast system clock, and bus clock rising edges are found by oversampling. The register file sees a one-cycle write strobe with address and data. It also sees a read address, and returns read data combinationally. The bus data pad is split into an input, an output and an output enable, so the pad cell and tri-state buffer sit outside the block. The system clock must run several times faster than the bus clock, which is at most 20 MHz.

Top module: `dbus_slave`

## Requirements
- R1: A frame is sampled on bus clock rising edges while the enable is low, in this bit order: device select (3 bits), direction (1 bit, where 1 means read), register index (5 bits), data (16 bits). Every field is sent MSB first, and a write stores the 16 data bits at the given index.
- R2: A frame whose device select is not `101` has no effect. It produces no write strobe, and the data output enable stays low for the whole frame.
- R3: A write commits on the second bus clock rising edge that sees the enable high after the 16th data bit. Exactly one single-cycle write strobe is produced, one system clock after that edge is detected. Nothing is committed at the first high edge.
- R4: If the enable rises before all 16 write data bits have been received, the frame is dropped. No strobe is issued and the register keeps its old value.
- R5: If the enable falls again before the second high edge of a completed write, that write is dropped, and the low-enable edge is taken as the first device-select bit of a new frame.
- R6: During a read, the output enable stays low through the 9 header bits. From the 10th rising edge on, the slave drives the addressed register's bits, one per rising edge, bit 15 first.
- R7: During a read, the slave stops driving the data line on the first bus clock rising edge that sees the enable high.
- R8: Write data bits received after the 16th, before the enable rises, are ignored. The first 16 bits are the ones committed.
- R9: After reset, the data output enable, the data output and the write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbus_clk | input | 1 | Bus clock from the master |
| dbus_en_n | input | 1 | Active-low frame enable from the master |
| dbus_din | input | 1 | Data line as seen at the pad input |
| dbus_dout | output | 1 | Data the slave drives during a read |
| dbus_doe | output | 1 | Output enable for the data pad |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 5 | Register index for the write |
| reg_wr_data | output | 16 | Register write data |
| reg_rd_addr | output | 5 | Register index for the read |
| reg_rd_data | input | 16 | Register contents for reg_rd_addr |

## Verification
The hardest situation to reach from the ports is the narrow window after the last write data bit, where the enable is high but only one qualifying edge has occurred. A write in that window must neither commit early nor survive a re-lowered enable. Frames cut short, or run past 16 data bits, also need deliberate stimulus. The bus master tasks in the bench take the number of data bits and the number of high-enable edges as arguments. This lets directed frames stop exactly at one edge and then check or restart. Randomly chosen register indices, data values, directions and device selects then mix reads and writes against a register model kept in the bench.

// File: rtl/dbus_slave_pkg.sv
package dbus_slave_pkg;

  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_HDR   = 3'd1,
    FS_WDATA = 3'd2,
    FS_HOLD  = 3'd3,
    FS_RDATA = 3'd4,
    FS_SKIP  = 3'd5
  } frame_state_e;

endpackage

// File: rtl/dbus_sync.sv
// Multi-bit input synchroniser with a rising-edge detector on bit 0.
module dbus_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             rise_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic             prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RESET_VAL;
        else        stage_q[0] <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RESET_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_VAL[0];
    else        prev_q <= sync_o[0];
  end

  assign rise_o = sync_o[0] & ~prev_q;

endmodule

// File: rtl/dbus_frame_ctl.sv
// Frame decoder: header capture, write data capture, commit window, read sequencing.
module dbus_frame_ctl
  import dbus_slave_pkg::*;
#(
  parameter int               DEV_W      = 3,
  parameter logic [DEV_W-1:0] DEV_ID     = 3'b101,
  parameter int               REG_AW     = 5,
  parameter int               DATA_W     = 16,
  parameter int               HOLD_EDGES = 2   // must be 2 or more
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise_i,
  input  logic              en_n_i,
  input  logic              din_i,
  output logic              rd_start_o,
  output logic              rd_step_o,
  output logic              rd_release_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int HDR_BITS = DEV_W + 1 + REG_AW;
  localparam int CNT_W    = $clog2(HDR_BITS + DATA_W + 1);
  localparam int HOLD_W   = $clog2(HOLD_EDGES + 1);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0]  LAST_HDR  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0]  DATA_FULL = CNT_W'(DATA_W);
  localparam logic [HOLD_W-1:0] HOLD_ONE  = HOLD_W'(1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_EDGES - 1);

  frame_state_e        state_q, state_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [HDR_BITS-1:0] hdr_q, hdr_n;
  logic [DATA_W-1:0]   dat_q, dat_n;
  logic [HOLD_W-1:0]   hold_q, hold_n;
  logic [REG_AW-1:0]   addr_q, addr_n;
  logic                stb_q, stb_n;

  logic [HDR_BITS-1:0] hdr_shift;
  logic [HDR_BITS-1:0] hdr_first;
  logic [DEV_W-1:0]    hdr_dev;
  logic                hdr_rd;
  logic [REG_AW-1:0]   hdr_addr;

  assign hdr_shift = {hdr_q[HDR_BITS-2:0], din_i};
  assign hdr_first = {{(HDR_BITS-1){1'b0}}, din_i};
  assign hdr_dev   = hdr_shift[HDR_BITS-1 -: DEV_W];
  assign hdr_rd    = hdr_shift[REG_AW];
  assign hdr_addr  = hdr_shift[REG_AW-1:0];

  always_comb begin
    state_n      = state_q;
    cnt_n        = cnt_q;
    hdr_n        = hdr_q;
    dat_n        = dat_q;
    hold_n       = hold_q;
    addr_n       = addr_q;
    stb_n        = 1'b0;
    rd_start_o   = 1'b0;
    rd_step_o    = 1'b0;
    rd_release_o = 1'b0;
    if (bit_rise_i) begin
      unique case (state_q)
        FS_IDLE: begin
          if (!en_n_i) begin
            hdr_n   = hdr_first;
            cnt_n   = CNT_ONE;
            state_n = FS_HDR;
          end
        end
        FS_HDR: begin
          if (en_n_i) begin
            state_n = FS_IDLE;
          end else begin
            hdr_n = hdr_shift;
            cnt_n = cnt_q + CNT_ONE;
            if (cnt_q == LAST_HDR) begin
              cnt_n  = '0;
              addr_n = hdr_addr;
              if (hdr_dev != DEV_ID) state_n = FS_SKIP;
              else if (hdr_rd)       state_n = FS_RDATA;
              else                   state_n = FS_WDATA;
            end
          end
        end
        FS_WDATA: begin
          if (en_n_i) begin
            if (cnt_q == DATA_FULL) begin
              state_n = FS_HOLD;
              hold_n  = HOLD_ONE;
            end else begin
              state_n = FS_IDLE;
            end
          end else if (cnt_q != DATA_FULL) begin
            dat_n = {dat_q[DATA_W-2:0], din_i};
            cnt_n = cnt_q + CNT_ONE;
          end
        end
        FS_HOLD: begin
          if (en_n_i) begin
            if (hold_q == HOLD_LAST) begin
              stb_n   = 1'b1;
              state_n = FS_IDLE;
            end else begin
              hold_n = hold_q + HOLD_ONE;
            end
          end else begin
            hdr_n   = hdr_first;
            cnt_n   = CNT_ONE;
            state_n = FS_HDR;
          end
        end
        FS_RDATA: begin
          if (en_n_i) begin
            rd_release_o = 1'b1;
            state_n      = FS_IDLE;
          end else if (cnt_q == '0) begin
            rd_start_o = 1'b1;
            cnt_n      = CNT_ONE;
          end else begin
            rd_step_o = 1'b1;
          end
        end
        FS_SKIP: begin
          if (en_n_i) state_n = FS_IDLE;
        end
        default: state_n = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
      hold_q  <= '0;
      addr_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= stb_n;
      if (bit_rise_i) begin
        state_q <= state_n;
        cnt_q   <= cnt_n;
        hdr_q   <= hdr_n;
        dat_q   <= dat_n;
        hold_q  <= hold_n;
        addr_q  <= addr_n;
      end
    end
  end

  assign reg_addr_o = addr_q;
  assign wr_stb_o   = stb_q;
  assign wr_data_o  = dat_q;

endmodule

// File: rtl/dbus_rd_shift.sv
// Read-data serialiser and pad output enable.
module dbus_rd_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              release_i,
  input  logic [DATA_W-1:0] par_i,
  output logic              sd_o,
  output logic              oe_o
);

  logic [DATA_W-1:0] sr_q, sr_n;
  logic              sd_q, sd_n;
  logic              oe_q, oe_n;

  always_comb begin
    sr_n = sr_q;
    sd_n = sd_q;
    oe_n = oe_q;
    if (release_i) begin
      sr_n = '0;
      sd_n = 1'b0;
      oe_n = 1'b0;
    end else if (start_i) begin
      sd_n = par_i[DATA_W-1];
      sr_n = {par_i[DATA_W-2:0], 1'b0};
      oe_n = 1'b1;
    end else if (step_i) begin
      sd_n = sr_q[DATA_W-1];
      sr_n = {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      sd_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      sr_q <= sr_n;
      sd_q <= sd_n;
      oe_q <= oe_n;
    end
  end

  assign sd_o = sd_q;
  assign oe_o = oe_q;

endmodule

// File: rtl/dbus_slave.sv
module dbus_slave #(
  parameter int               DEV_W      = 3,
  parameter logic [DEV_W-1:0] DEV_ID     = 3'b101,
  parameter int               REG_AW     = 5,
  parameter int               DATA_W     = 16,
  parameter int               SYNC_DEPTH = 2,
  parameter int               HOLD_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbus_clk,
  input  logic              dbus_en_n,
  input  logic              dbus_din,
  output logic              dbus_dout,
  output logic              dbus_doe,
  output logic              reg_wr_stb,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_int;
  logic [2:0]            bus_sync;
  logic                  bus_rise;
  logic                  en_n_s;
  logic                  din_s;
  logic                  rd_start, rd_step, rd_release;
  logic [REG_AW-1:0]     reg_addr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[RST_STAGES-1];

  dbus_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_DEPTH),
    .RESET_VAL(3'b010)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .async_i({dbus_din, dbus_en_n, dbus_clk}),
    .sync_o (bus_sync),
    .rise_o (bus_rise)
  );

  assign en_n_s = bus_sync[1];
  assign din_s  = bus_sync[2];

  dbus_frame_ctl #(
    .DEV_W     (DEV_W),
    .DEV_ID    (DEV_ID),
    .REG_AW    (REG_AW),
    .DATA_W    (DATA_W),
    .HOLD_EDGES(HOLD_EDGES)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .bit_rise_i  (bus_rise),
    .en_n_i      (en_n_s),
    .din_i       (din_s),
    .rd_start_o  (rd_start),
    .rd_step_o   (rd_step),
    .rd_release_o(rd_release),
    .reg_addr_o  (reg_addr),
    .wr_stb_o    (reg_wr_stb),
    .wr_data_o   (reg_wr_data)
  );

  dbus_rd_shift #(
    .DATA_W(DATA_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (rd_start),
    .step_i   (rd_step),
    .release_i(rd_release),
    .par_i    (reg_rd_data),
    .sd_o     (dbus_dout),
    .oe_o     (dbus_doe)
  );

  assign reg_wr_addr = reg_addr;
  assign reg_rd_addr = reg_addr;

endmodule

// File: rtl/dbus_slave_chk.sv
module dbus_slave_chk #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              bus_rise,
  input logic              en_n_s,
  input logic              dbus_doe,
  input logic              reg_wr_stb,
  input logic [REG_AW-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data
);

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_wr_stb |=> !reg_wr_stb);

  // R3
  strobe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_wr_stb |-> $past(bus_rise && en_n_s));

  // R1
  strobe_payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_wr_stb |-> ($stable(reg_wr_data) && $stable(reg_wr_addr)));

  // R6
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(dbus_doe) |-> $past(bus_rise && !en_n_s));

  // R7
  drive_stop_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(dbus_doe) |-> $past(bus_rise && en_n_s));

  // R6
  no_write_while_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    dbus_doe |-> !reg_wr_stb);

endmodule

bind dbus_slave dbus_slave_chk #(
  .REG_AW(REG_AW),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n_int  (rst_n_int),
  .bus_rise   (bus_rise),
  .en_n_s     (en_n_s),
  .dbus_doe   (dbus_doe),
  .reg_wr_stb (reg_wr_stb),
  .reg_wr_addr(reg_wr_addr),
  .reg_wr_data(reg_wr_data)
);

// File: tb/dbus_slave_tb.sv
module dbus_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;

  logic        clk;
  logic        rst_n;
  logic        dbus_clk;
  logic        dbus_en_n;
  logic        dbus_din;
  logic        dbus_dout;
  logic        dbus_doe;
  logic        reg_wr_stb;
  logic [4:0]  reg_wr_addr;
  logic [15:0] reg_wr_data;
  logic [4:0]  reg_rd_addr;
  logic [15:0] reg_rd_data;

  logic [15:0] rf    [32];
  logic [15:0] model [32];
  int          stb_cycles;
  int          checks;
  int          errors;

  dbus_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbus_clk   (dbus_clk),
    .dbus_en_n  (dbus_en_n),
    .dbus_din   (dbus_din),
    .dbus_dout  (dbus_dout),
    .dbus_doe   (dbus_doe),
    .reg_wr_stb (reg_wr_stb),
    .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // register file attached to the slave
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 16'h0000;
      stb_cycles <= 0;
    end else if (reg_wr_stb) begin
      rf[reg_wr_addr] <= reg_wr_data;
      stb_cycles      <= stb_cycles + 1;
    end
  end
  assign reg_rd_data = rf[reg_rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] hdr_bits(input logic [2:0] dev, input logic rd,
                                          input logic [4:0] addr);
    return {dev, rd, addr};
  endfunction

  task automatic bus_bit(input logic b);
    dbus_din = b;
    #HALF dbus_clk = 1'b1;
    #HALF dbus_clk = 1'b0;
  endtask

  task automatic hold_edges(input int n);
    for (int i = 0; i < n; i++) begin
      #HALF dbus_clk = 1'b1;
      #HALF dbus_clk = 1'b0;
    end
  endtask

  task automatic idle_gap();
    #(4 * HALF);
  endtask

  task automatic do_write(input logic [2:0] dev, input logic [4:0] addr,
                          input logic [15:0] data, input int ndata, input int nhold);
    logic [8:0] h;
    h = hdr_bits(dev, 1'b0, addr);
    dbus_en_n = 1'b0;
    for (int i = 8; i >= 0; i--) bus_bit(h[i]);
    for (int i = 0; i < ndata; i++) bus_bit(i < 16 ? data[15-i] : 1'b1);
    dbus_en_n = 1'b1;
    hold_edges(nhold);
  endtask

  task automatic do_read(input logic [2:0] dev, input logic [4:0] addr,
                         output logic [15:0] val, output bit oe_all, output bit oe_any,
                         output bit oe_hdr, output bit oe_after);
    logic [8:0] h;
    h = hdr_bits(dev, 1'b1, addr);
    val = '0; oe_all = 1'b1; oe_any = 1'b0;
    dbus_en_n = 1'b0;
    for (int i = 8; i >= 0; i--) bus_bit(h[i]);
    oe_hdr   = dbus_doe;
    dbus_din = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      #HALF dbus_clk = 1'b1;
      #HALF;
      val[i] = dbus_dout;
      oe_all = oe_all & dbus_doe;
      oe_any = oe_any | dbus_doe;
      dbus_clk = 1'b0;
    end
    dbus_en_n = 1'b1;
    #HALF dbus_clk = 1'b1;
    #HALF;
    oe_after = dbus_doe;
    dbus_clk = 1'b0;
    idle_gap();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bit oa, on, oh, of;
    int s0;
    int seed;
    checks = 0; errors = 0;
    dbus_clk = 1'b0; dbus_en_n = 1'b1; dbus_din = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    rst_n = 1'b0;
    #(5 * CLK_PERIOD);
    @(negedge clk) rst_n = 1'b1;
    #(5 * CLK_PERIOD);

    // R9 reset state
    chk(dbus_doe == 1'b0, "R9 doe", dbus_doe, 0);
    chk(dbus_dout == 1'b0, "R9 dout", dbus_dout, 0);
    chk(reg_wr_stb == 1'b0, "R9 stb", reg_wr_stb, 0);

    // R1 basic write then read back
    do_write(3'b101, 5'd3, 16'hA5C3, 16, 2); idle_gap();
    chk(stb_cycles == 1, "R1 write strobe", stb_cycles, 1);
    model[3] = 16'hA5C3;
    do_read(3'b101, 5'd3, v, oa, on, oh, of);
    chk(v == 16'hA5C3, "R1 read back", v, 16'hA5C3);
    chk(oh == 1'b0, "R6 no drive in header", oh, 0);
    chk(oa == 1'b1, "R6 drive during data", oa, 1);
    chk(of == 1'b0, "R7 release", of, 0);

    // R3 nothing at first high edge, commit at second
    s0 = stb_cycles;
    do_write(3'b101, 5'd7, 16'h1234, 16, 1); #(2 * HALF);
    chk(stb_cycles == s0, "R3 no commit at first edge", stb_cycles, s0);
    hold_edges(1); idle_gap();
    chk(stb_cycles == s0 + 1, "R3 commit at second edge", stb_cycles, s0 + 1);
    model[7] = 16'h1234;
    do_read(3'b101, 5'd7, v, oa, on, oh, of);
    chk(v == 16'h1234, "R3 committed value", v, 16'h1234);

    // R5 hold interrupted: the new frame starts on the low edge
    s0 = stb_cycles;
    do_write(3'b101, 5'd3, 16'h0F0F, 16, 1);
    do_read(3'b101, 5'd3, v, oa, on, oh, of);
    chk(stb_cycles == s0, "R5 no strobe", stb_cycles, s0);
    chk(v == model[3], "R5 old value kept", v, model[3]);

    // R4 short write
    s0 = stb_cycles;
    do_write(3'b101, 5'd7, 16'hFFFF, 10, 2); idle_gap();
    chk(stb_cycles == s0, "R4 no strobe", stb_cycles, s0);
    do_read(3'b101, 5'd7, v, oa, on, oh, of);
    chk(v == model[7], "R4 value unchanged", v, model[7]);

    // R8 overlong write keeps first 16 bits
    do_write(3'b101, 5'd31, 16'h8421, 20, 2); idle_gap();
    model[31] = 16'h8421;
    do_read(3'b101, 5'd31, v, oa, on, oh, of);
    chk(v == 16'h8421, "R8 first 16 bits", v, 16'h8421);

    // R2 foreign device select
    s0 = stb_cycles;
    do_write(3'b100, 5'd3, 16'hDEAD, 16, 2); idle_gap();
    chk(stb_cycles == s0, "R2 write ignored", stb_cycles, s0);
    do_read(3'b111, 5'd3, v, oa, on, oh, of);
    chk(on == 1'b0, "R2 read not driven", on, 0);
    do_read(3'b101, 5'd3, v, oa, on, oh, of);
    chk(v == model[3], "R2 register unchanged", v, model[3]);

    // random mix
    seed = $urandom(32'h1F2E);
    for (int n = 0; n < 40; n++) begin
      logic [2:0]  dev;
      logic [4:0]  a;
      logic [15:0] d;
      bit          ok;
      int          dsel;
      ok = ($urandom % 5) != 0;
      if (ok) dev = 3'b101;
      else begin
        dsel = $urandom % 7;
        if (dsel >= 5) dsel++;
        dev = 3'(dsel);
      end
      a = 5'($urandom);
      d = 16'($urandom);
      if (($urandom % 2) == 0) begin
        s0 = stb_cycles;
        do_write(dev, a, d, 16, 2); idle_gap();
        chk(stb_cycles == s0 + (ok ? 1 : 0), ok ? "R1 random write" : "R2 random write",
            stb_cycles, s0 + (ok ? 1 : 0));
        if (ok) model[a] = d;
      end else begin
        do_read(dev, a, v, oa, on, oh, of);
        if (ok) chk(v == model[a] && oa && !oh && !of, "R6 random read", v, model[a]);
        else    chk(on == 1'b0, "R2 random read", on, 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule